// File: doc/BRIEF.md
# Decoder Data Burst Feeder

This block moves audio bytes from a circular byte buffer into the serial data input of an audio decoder. The serial path is transmit-only and SPI-like: the block drives the clock and the data line, and a select line that picks the decoder's data port. The buffer itself sits outside the block. The feeder drives a read address, takes the byte at that address in the same cycle, and sees the buffer's current fill count.

After reset the feeder sends two zero bytes, which prime the decoder's data port. From then on it waits for the decoder to request data. A burst starts only when the request line is high and the buffer holds at least one burst's worth of bytes. A burst is a run of back-to-back bytes, each framed by a byte-sync strobe during its first bit. At the end of a burst the feeder pulses a decrement strobe, so the buffer owner subtracts one burst length from its count.

The feeder also keeps a low-water mark: the smallest fill level it has observed. Diagnostics read this value.

Top module: `feeder_burst`

## Requirements
- R1: After reset, before any burst, the feeder sends two bytes of value 0x00. It does this without waiting for the request line.
- R2: A burst starts only while the feeder is idle, `dreq_i` is high and `fill_count_i` >= BURST_LEN. Otherwise no byte is sent and `cnt_dec_o` stays low.
- R3: A burst sends exactly BURST_LEN bytes, read in order from consecutive addresses. The address wraps from DEPTH-1 to 0, and the position carries over from one burst to the next.
- R4: Bits go out MSB first. `sclk_o` idles low and data is stable at each rising edge. One bit takes CLK_DIV (4) system clocks, with no gap between the bytes of a burst.
- R5: `bsync_o` is high at the rising clock edge of the first bit of every byte, and low at the other seven.
- R6: `xcs_o` is high whenever `sclk_o` or `bsync_o` is high, so that the decoder's data port is selected.
- R7: Each burst gives exactly one single-cycle `cnt_dec_o` pulse, in the cycle the last bit ends.
- R8: `busy_o` holds from burst start until the last bit has been shifted. A request raised during a burst does not start a second burst.
- R9: `min_level_o` resets to all ones (255). Each check updates it to the smaller of its current value and a new candidate. When a high request finds too few bytes, the candidate is the fill count. At burst end, the candidate is the fill count minus BURST_LEN. The value never increases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dreq_i | input | 1 | Data request from the decoder |
| fill_count_i | input | CNT_W | Bytes currently held in the buffer |
| rd_addr_o | output | ADDR_W | Buffer read address |
| rd_data_i | input | 8 | Buffer byte at `rd_addr_o`, same cycle |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data, MSB first |
| bsync_o | output | 1 | Byte-sync strobe during each byte's first bit |
| xcs_o | output | 1 | Data-port select, high while shifting |
| cnt_dec_o | output | 1 | Pulse: subtract BURST_LEN from the count |
| busy_o | output | 1 | Priming or burst in progress |
| min_level_o | output | CNT_W | Lowest fill level observed |

## Verification
The bench builds the feeder with BURST_LEN=4, DEPTH=10 and CLK_DIV=4. With these values a burst is 128 cycles long, and the read address wraps both inside a single burst and between bursts. The small buffer also lets fill levels below, at and above one burst be reached quickly, so that R2 and R9 are exercised at their boundaries. The bench captures the serial stream on every rising serial-clock edge and checks the bit period, the strobe placement and the select line bit by bit.

// File: rtl/feeder_pkg.sv
package feeder_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PRE_BYTES = 2;

  typedef enum logic [1:0] {
    FD_PRIME = 2'd0,
    FD_IDLE  = 2'd1,
    FD_BURST = 2'd2
  } fd_state_e;
endpackage

// File: rtl/feeder_shift.sv
module feeder_shift #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       ready_o,
  output logic       done_o,
  output logic       active_o,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       bsync_o
);
  localparam int unsigned PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int unsigned HALF = CLK_DIV / 2;

  logic            active_q;
  logic [PH_W-1:0] ph_q;
  logic [2:0]      bit_q;
  logic [7:0]      sh_q;
  logic            last_ph;

  assign last_ph  = (ph_q == PH_W'(CLK_DIV - 1));
  assign done_o   = active_q && last_ph && (bit_q == 3'd7);
  assign ready_o  = !active_q || done_o;
  assign active_o = active_q;
  assign sclk_o   = active_q && (ph_q >= PH_W'(HALF));
  assign mosi_o   = active_q && sh_q[7];
  // strobe covers the whole first bit, low half included
  assign bsync_o  = active_q && (bit_q == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ph_q     <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      ph_q     <= '0;
      bit_q    <= '0;
      sh_q     <= byte_i;
    end else if (active_q) begin
      if (last_ph) begin
        ph_q <= '0;
        if (bit_q == 3'd7) begin
          active_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 3'd1;
          sh_q  <= {sh_q[6:0], 1'b0};
        end
      end else begin
        ph_q <= ph_q + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/feeder_ctrl.sv
module feeder_ctrl
  import feeder_pkg::*;
#(
  parameter int unsigned BURST_LEN = 32,
  parameter int unsigned DEPTH     = 256,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CNT_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dreq_i,
  input  logic [CNT_W-1:0]  fill_count_i,
  input  logic [7:0]        rd_data_i,
  input  logic              sh_ready_i,
  input  logic              sh_done_i,
  output logic              load_o,
  output logic [7:0]        load_byte_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              busy_o,
  output logic              cnt_dec_o,
  output logic              lm_upd_o,
  output logic [CNT_W-1:0]  lm_val_o
);
  localparam int unsigned BC_W = $clog2(BURST_LEN + PRE_BYTES + 1);

  fd_state_e         state_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [BC_W-1:0]   nload_q;
  logic              enough;
  logic              start;
  logic              prime_load;
  logic              burst_load;
  logic              prime_end;
  logic              burst_end;

  assign enough     = (fill_count_i >= CNT_W'(BURST_LEN));
  assign start      = (state_q == FD_IDLE) && dreq_i && enough;
  assign prime_load = (state_q == FD_PRIME) && sh_ready_i && (nload_q < BC_W'(PRE_BYTES));
  assign burst_load = (state_q == FD_BURST) && sh_ready_i && (nload_q < BC_W'(BURST_LEN));
  assign prime_end  = (state_q == FD_PRIME) && (nload_q == BC_W'(PRE_BYTES)) && sh_done_i;
  assign burst_end  = (state_q == FD_BURST) && (nload_q == BC_W'(BURST_LEN)) && sh_done_i;

  assign load_o      = prime_load || start || burst_load;
  assign load_byte_o = (state_q == FD_PRIME) ? 8'h00 : rd_data_i;
  assign rd_addr_o   = ptr_q;
  assign busy_o      = (state_q != FD_IDLE);
  // combinational so the owner's count is current when IDLE is next seen
  assign cnt_dec_o   = burst_end;
  assign lm_upd_o    = burst_end || ((state_q == FD_IDLE) && dreq_i && !enough);
  assign lm_val_o    = burst_end ? (fill_count_i - CNT_W'(BURST_LEN)) : fill_count_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FD_PRIME;
      ptr_q   <= '0;
      nload_q <= '0;
    end else begin
      if (start || burst_load) begin
        ptr_q <= (ptr_q == ADDR_W'(DEPTH - 1)) ? '0 : ptr_q + ADDR_W'(1);
      end
      unique case (state_q)
        FD_PRIME: begin
          if (prime_end) begin
            state_q <= FD_IDLE;
            nload_q <= '0;
          end else if (prime_load) begin
            nload_q <= nload_q + BC_W'(1);
          end
        end
        FD_IDLE: begin
          if (start) begin
            state_q <= FD_BURST;
            nload_q <= BC_W'(1);
          end
        end
        FD_BURST: begin
          if (burst_end) begin
            state_q <= FD_IDLE;
            nload_q <= '0;
          end else if (burst_load) begin
            nload_q <= nload_q + BC_W'(1);
          end
        end
        default: state_q <= FD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/feeder_lowmark.sv
module feeder_lowmark #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] val_i,
  output logic [CNT_W-1:0] min_o
);
  logic [CNT_W-1:0] min_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q <= '1;
    end else if (upd_i && (val_i < min_q)) begin
      min_q <= val_i;
    end
  end

  assign min_o = min_q;
endmodule

// File: rtl/feeder_burst.sv
module feeder_burst #(
  parameter  int unsigned BURST_LEN = 32,
  parameter  int unsigned DEPTH     = 256,
  parameter  int unsigned CNT_W     = 8,
  parameter  int unsigned CLK_DIV   = 4,
  localparam int unsigned ADDR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dreq_i,
  input  logic [CNT_W-1:0]  fill_count_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              bsync_o,
  output logic              xcs_o,
  output logic              cnt_dec_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  min_level_o
);
  logic             sh_load;
  logic [7:0]       sh_byte;
  logic             sh_ready;
  logic             sh_done;
  logic             sh_active;
  logic             lm_upd;
  logic [CNT_W-1:0] lm_val;

  feeder_ctrl #(
    .BURST_LEN(BURST_LEN),
    .DEPTH    (DEPTH),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dreq_i      (dreq_i),
    .fill_count_i(fill_count_i),
    .rd_data_i   (rd_data_i),
    .sh_ready_i  (sh_ready),
    .sh_done_i   (sh_done),
    .load_o      (sh_load),
    .load_byte_o (sh_byte),
    .rd_addr_o   (rd_addr_o),
    .busy_o      (busy_o),
    .cnt_dec_o   (cnt_dec_o),
    .lm_upd_o    (lm_upd),
    .lm_val_o    (lm_val)
  );

  feeder_shift #(
    .CLK_DIV(CLK_DIV)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .byte_i  (sh_byte),
    .ready_o (sh_ready),
    .done_o  (sh_done),
    .active_o(sh_active),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .bsync_o (bsync_o)
  );

  feeder_lowmark #(
    .CNT_W(CNT_W)
  ) u_lowmark (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (lm_upd),
    .val_i (lm_val),
    .min_o (min_level_o)
  );

  assign xcs_o = sh_active;
endmodule

// File: rtl/feeder_burst_chk.sv
module feeder_burst_chk #(
  parameter int unsigned BURST_LEN = 32,
  parameter int unsigned CNT_W     = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dreq_i,
  input logic [CNT_W-1:0] fill_count_i,
  input logic             sclk_o,
  input logic             bsync_o,
  input logic             xcs_o,
  input logic             cnt_dec_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] min_level_o
);
  // R6
  sel_on_sclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> xcs_o);

  // R6
  sel_on_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsync_o |-> xcs_o);

  // R7
  dec_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_dec_o |=> !cnt_dec_o);

  // R7
  dec_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_dec_o |-> busy_o);

  // R2
  start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(dreq_i) && ($past(fill_count_i) >= CNT_W'(BURST_LEN))));

  // R9
  min_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(min_level_o) |=> (min_level_o <= $past(min_level_o)));
endmodule

bind feeder_burst feeder_burst_chk #(
  .BURST_LEN(BURST_LEN),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dreq_i      (dreq_i),
  .fill_count_i(fill_count_i),
  .sclk_o      (sclk_o),
  .bsync_o     (bsync_o),
  .xcs_o       (xcs_o),
  .cnt_dec_o   (cnt_dec_o),
  .busy_o      (busy_o),
  .min_level_o (min_level_o)
);

// File: tb/feeder_burst_bench.sv
`timescale 1ns/1ps
module feeder_burst_bench;
  localparam int BL    = 4;
  localparam int DEPTH = 10;
  localparam int CNT_W = 8;
  localparam int DIV   = 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int BURST_CYC = DIV * 8 * BL;

  // {fill[15:8], dreq[7:4], burst_expected[3:0]}
  localparam logic [15:0] VEC [7] = '{
    16'h0200, 16'h0310, 16'h0400, 16'h0911, 16'h0611, 16'h0411, 16'hC811
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             dreq_i = 1'b0;
  logic [CNT_W-1:0] fill_w;
  logic [AW-1:0]    rd_addr_o;
  logic [7:0]       rd_data_i;
  logic             sclk_o, mosi_o, bsync_o, xcs_o, cnt_dec_o, busy_o;
  logic [CNT_W-1:0] min_level_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int dec_n = 0;
  int dec_base = 0;
  logic [7:0] fill_base = 8'd0;
  logic [7:0] cap [0:63];
  int ncap = 0;
  int bitn = 0;
  logic [7:0] cur = 8'd0;
  int last_rise = 0;
  int eptr = 0;
  int emin = 255;

  always #2 clk_i = ~clk_i;

  function automatic logic [7:0] mem_val(input int a);
    return 8'((a * 37 + 90) & 255);
  endfunction

  assign rd_data_i = mem_val(int'(rd_addr_o));
  assign fill_w    = fill_base - 8'(BL * (dec_n - dec_base));

  feeder_burst #(
    .BURST_LEN(BL), .DEPTH(DEPTH), .CNT_W(CNT_W), .CLK_DIV(DIV)
  ) u_feeder_burst (
    .clk_i(clk_i), .rst_ni(rst_ni), .dreq_i(dreq_i), .fill_count_i(fill_w),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .bsync_o(bsync_o), .xcs_o(xcs_o), .cnt_dec_o(cnt_dec_o),
    .busy_o(busy_o), .min_level_o(min_level_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (rst_ni && cnt_dec_o) dec_n <= dec_n + 1;
  end

  // serial monitor: R4 R5 R6
  always @(posedge sclk_o) begin
    chk(xcs_o == 1'b1, "R6 select high while clocking", int'(xcs_o), 1);
    chk(bsync_o == (bitn == 0), "R5 byte sync on first bit", int'(bsync_o), int'(bitn == 0));
    if (bitn != 0) chk(cyc - last_rise == DIV, "R4 bit period", cyc - last_rise, DIV);
    last_rise = cyc;
    cur = {cur[6:0], mosi_o};
    bitn++;
    if (bitn == 8) begin
      cap[ncap] = cur;
      ncap++;
      bitn = 0;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic check_bytes(input int n0, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      chk(cap[n0 + k] == mem_val(eptr), "R3 byte order and wrap", int'(cap[n0 + k]), int'(mem_val(eptr)));
      eptr = (eptr == DEPTH - 1) ? 0 : eptr + 1;
    end
  endtask

  initial begin
    wait_cyc(3);
    // reset state
    chk(sclk_o == 0, "R4 sclk idle in reset", int'(sclk_o), 0);
    chk(bsync_o == 0 && cnt_dec_o == 0, "R7 no strobes in reset", int'(bsync_o | cnt_dec_o), 0);
    chk(min_level_o == 8'hFF, "R9 low-water reset", int'(min_level_o), 255);
    rst_ni = 1'b1;

    // priming
    wait_cyc(2 * 8 * DIV + 12);
    chk(ncap == 2, "R1 priming byte count", ncap, 2);
    chk(cap[0] == 8'h00 && cap[1] == 8'h00, "R1 priming bytes zero", int'(cap[0] | cap[1]), 0);
    chk(busy_o == 0, "R8 idle after priming", int'(busy_o), 0);
    chk(dec_n == 0, "R7 no decrement for priming", dec_n, 0);

    for (int v = 0; v < 7; v++) begin
      int n0, d0, f;
      bit dq, eb;
      f  = int'(VEC[v][15:8]);
      dq = VEC[v][4];
      eb = VEC[v][0];
      fill_base = 8'(f);
      dec_base = dec_n;
      n0 = ncap;
      d0 = dec_n;
      dreq_i = dq;
      wait_cyc(3);
      dreq_i = 1'b0;
      wait_cyc(BURST_CYC + 20);
      chk(ncap - n0 == (eb ? BL : 0), "R2 burst gating", ncap - n0, eb ? BL : 0);
      chk(dec_n - d0 == (eb ? 1 : 0), "R7 one decrement per burst", dec_n - d0, eb ? 1 : 0);
      if (eb && ncap - n0 == BL) check_bytes(n0, BL);
      if (dq) begin
        int cand;
        cand = eb ? f - BL : f;
        if (cand < emin) emin = cand;
      end
      chk(int'(min_level_o) == emin, "R9 low-water mark", int'(min_level_o), emin);
      chk(busy_o == 0, "R8 busy clears", int'(busy_o), 0);
    end

    // request raised mid-burst must not start a second burst
    begin
      int n0, d0;
      fill_base = 8'd20;
      dec_base = dec_n;
      n0 = ncap;
      d0 = dec_n;
      dreq_i = 1'b1;
      wait_cyc(3);
      dreq_i = 1'b0;
      wait_cyc(40);
      chk(busy_o == 1, "R8 busy during burst", int'(busy_o), 1);
      dreq_i = 1'b1;
      wait_cyc(50);
      dreq_i = 1'b0;
      wait_cyc(BURST_CYC + 20);
      chk(ncap - n0 == BL, "R8 no overlapping burst", ncap - n0, BL);
      chk(dec_n - d0 == 1, "R7 single decrement", dec_n - d0, 1);
      if (ncap - n0 == BL) check_bytes(n0, BL);
    end

    // request held: two bursts then stop on low count
    begin
      int n0, d0;
      fill_base = 8'd8;
      dec_base = dec_n;
      n0 = ncap;
      d0 = dec_n;
      dreq_i = 1'b1;
      wait_cyc(3 * BURST_CYC);
      dreq_i = 1'b0;
      wait_cyc(20);
      chk(ncap - n0 == 2 * BL, "R3 back-to-back bursts", ncap - n0, 2 * BL);
      chk(dec_n - d0 == 2, "R7 decrement per burst", dec_n - d0, 2);
      if (ncap - n0 == 2 * BL) check_bytes(n0, 2 * BL);
      chk(int'(min_level_o) == 0, "R9 low-water holds minimum", int'(min_level_o), 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule